// File: doc/BRIEF.md
# Configurable Product-Term Macrocell

This block is one logic cell of a programmable array. It forms up to five AND terms over an input vector. Each term picks, bit by bit, whether an input takes part and whether its true or inverted value is used. The enabled terms, together with any enabled expander terms that neighbouring cells supply, are ORed into a sum-of-products. The sum either goes to the cell output directly or feeds a flip-flop whose clock, enable, preset and clear sources are all set by configuration.

The register has three clocking modes: a global clock alone, a global clock qualified by an active-high enable, or a clock built from one of the product terms. Two global clock inputs exist, and either one may be used in true or inverted form. Preset and clear are active high and each comes from a selectable product term. An active-low global clear overrides both. A fast-input option loads the register from a dedicated pin instead of the sum.

The whole cell runs on one system clock. The selected clock source is sampled on that clock, and the register moves on a detected rising edge of the source, so no derived clock is ever created. The cell output is registered on the system clock.

Top module: `pld_macrocell`

## Requirements
- R1: Term k is the AND, over every input i whose use bit `cfg_pt_use[k*N_IN+i]` is 1, of `in_vec[i]` XOR `cfg_pt_inv[k*N_IN+i]`. A term with no use bit set evaluates to 1.
- R2: The sum is the OR of every term k with `cfg_pt_en[k]`=1 and every expander input j with `cfg_exp_en[j]`=1. With nothing enabled the sum is 0.
- R3: In global mode (`cfg_clk_mode`=0), the raw source is sampled on every system edge. A rising edge is seen at a system edge where the raw source is 1 and the previous sample was 0. The register loads its D value at that same system edge. In every other cycle, with no clear or preset active, it holds.
- R4: The global raw source is `gclk_a` when `cfg_gsel`=0 and `gclk_b` when it is 1. It is inverted when `cfg_ginv`=1.
- R5: In enabled-global mode (`cfg_clk_mode`=1), a detected edge loads the register only if `clk_en` is 1 in that same cycle.
- R6: In array mode (`cfg_clk_mode`=2), the raw source is term `cfg_arr_pt`. An index of N_PT or more gives a constant 0. Mode 3 never loads.
- R7: When `cfg_clr_on`=1 and term `cfg_clr_pt` is 1, the register goes to 0 at the next system edge, whatever the clock source does. When `cfg_pre_on`=1 and term `cfg_pre_pt` is 1, it goes to 1 in the same way. Clear wins over preset.
- R8: `gclr_n`=0 forces the register to 0 at the next system edge. This overrides preset and any clock edge.
- R9: During `rst` the register and `cell_out` are 0. The edge detector starts as if the previous sample were 1, so no edge is seen in the first cycle after reset.
- R10: With `cfg_fast`=1 the register D value is `fast_in`. With `cfg_fast`=0 it is the sum.
- R11: `cell_out` is updated on every system edge. It takes the sum when `cfg_comb`=1 and the register's new value when `cfg_comb`=0, so with `cfg_comb`=0 it always equals `q_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vec | input | N_IN | Inputs to the AND terms |
| exp_in | input | N_EXP | Expander terms from neighbouring cells |
| gclk_a | input | 1 | Global clock source A, sampled |
| gclk_b | input | 1 | Global clock source B, sampled |
| clk_en | input | 1 | Active-high enable for mode 1 |
| gclr_n | input | 1 | Active-low global clear |
| fast_in | input | 1 | Dedicated fast-load pin |
| cfg_pt_use | input | N_PT*N_IN | Per-term input participation mask |
| cfg_pt_inv | input | N_PT*N_IN | Per-term input complement select |
| cfg_pt_en | input | N_PT | Terms that enter the sum |
| cfg_exp_en | input | N_EXP | Expander inputs that enter the sum |
| cfg_clk_mode | input | 2 | 0 global, 1 global with enable, 2 array, 3 off |
| cfg_gsel | input | 1 | Global source select (0 A, 1 B) |
| cfg_ginv | input | 1 | Invert the global source |
| cfg_arr_pt | input | PTW | Term used as the array clock |
| cfg_pre_on | input | 1 | Enable the preset term |
| cfg_pre_pt | input | PTW | Term used as preset |
| cfg_clr_on | input | 1 | Enable the clear term |
| cfg_clr_pt | input | PTW | Term used as clear |
| cfg_fast | input | 1 | Register D from `fast_in` |
| cfg_comb | input | 1 | Output the sum instead of the register |
| q_out | output | 1 | Register state |
| cell_out | output | 1 | Registered cell output |

## Verification
The assertions assume that the clock sources change no faster than the system clock samples them. They also assume that configuration and data are steady around each system edge. The bench meets this by changing every input only on the falling system edge. It moves the global clocks and the array-clock term by random toggles, at most one change per cycle, and it changes configuration only between phases. Preset, clear and global clear are pulsed at random while the clock keeps running, so priority conflicts between them and clock edges occur often.

// File: rtl/mc_pkg.sv
package mc_pkg;
  typedef enum logic [1:0] {
    CK_GLOBAL    = 2'd0,
    CK_GLOBAL_EN = 2'd1,
    CK_ARRAY     = 2'd2,
    CK_OFF       = 2'd3
  } ck_mode_e;
endpackage

// File: rtl/mc_pterm_array.sv
module mc_pterm_array #(
  parameter int N_IN  = 8,
  parameter int N_PT  = 5,
  parameter int N_EXP = 2
) (
  input  logic [N_IN-1:0]      in_vec,
  input  logic [N_PT*N_IN-1:0] use_mask,
  input  logic [N_PT*N_IN-1:0] inv_mask,
  input  logic [N_PT-1:0]      pt_en,
  input  logic [N_EXP-1:0]     exp_in,
  input  logic [N_EXP-1:0]     exp_en,
  output logic [N_PT-1:0]      terms,
  output logic                 sop
);
  // each term: inputs not used are forced to 1 before the AND
  for (genvar k = 0; k < N_PT; k++) begin : g_term
    logic [N_IN-1:0] lit;
    assign lit = ~use_mask[k*N_IN +: N_IN]
               | (in_vec ^ inv_mask[k*N_IN +: N_IN]);
    assign terms[k] = &lit;
  end

  assign sop = (|(terms & pt_en)) | (|(exp_in & exp_en));
endmodule

// File: rtl/mc_clk_select.sv
module mc_clk_select
  import mc_pkg::*;
#(
  parameter int N_PT = 5,
  parameter int PTW  = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            gclk_a,
  input  logic            gclk_b,
  input  logic            gsel,
  input  logic            ginv,
  input  ck_mode_e        mode,
  input  logic            clk_en,
  input  logic [N_PT-1:0] terms,
  input  logic [PTW-1:0]  arr_sel,
  output logic            load
);
  localparam int SLOTS = 1 << PTW;

  logic [SLOTS-1:0] term_pad;
  logic             g_raw, raw, prev, rise;

  assign term_pad = SLOTS'(terms);
  assign g_raw    = (gsel ? gclk_b : gclk_a) ^ ginv;

  always_comb begin
    unique case (mode)
      CK_GLOBAL, CK_GLOBAL_EN: raw = g_raw;
      CK_ARRAY:                raw = term_pad[arr_sel];
      default:                 raw = 1'b0;
    endcase
  end

  // previous sample starts at 1 so reset release never looks like an edge
  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b1;
    else     prev <= raw;
  end

  assign rise = raw & ~prev;

  always_comb begin
    unique case (mode)
      CK_GLOBAL, CK_ARRAY: load = rise;
      CK_GLOBAL_EN:        load = rise & clk_en;
      default:             load = 1'b0;
    endcase
  end

  a_r5_enable_gate: assert property (@(posedge clk) disable iff (rst)
    (mode == CK_GLOBAL_EN && !clk_en) |-> !load);
  a_r6_off_mode: assert property (@(posedge clk) disable iff (rst)
    (mode == CK_OFF) |-> !load);
  a_r9_no_edge_after_reset: assert property (@(posedge clk)
    rst |=> !load);
endmodule

// File: rtl/mc_reg_ctl.sv
module mc_reg_ctl (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic d,
  input  logic pre_req,
  input  logic clr_req,
  input  logic gclr_n,
  input  logic comb_sel,
  input  logic sop,
  output logic q,
  output logic cell_out
);
  logic q_nxt;

  always_comb begin
    if (!gclr_n || clr_req) q_nxt = 1'b0;
    else if (pre_req)       q_nxt = 1'b1;
    else if (load)          q_nxt = d;
    else                    q_nxt = q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q        <= 1'b0;
      cell_out <= 1'b0;
    end else begin
      q        <= q_nxt;
      cell_out <= comb_sel ? sop : q_nxt;
    end
  end

  a_r9_reset_low: assert property (@(posedge clk)
    rst |=> (!q && !cell_out));
  a_r8_global_clear: assert property (@(posedge clk) disable iff (rst)
    !gclr_n |=> !q);
  a_r7_clear_wins: assert property (@(posedge clk) disable iff (rst)
    clr_req |=> !q);
  a_r7_preset: assert property (@(posedge clk) disable iff (rst)
    (gclr_n && !clr_req && pre_req) |=> q);
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    (gclr_n && !clr_req && !pre_req && !load) |=> $stable(q));
  a_r3_load: assert property (@(posedge clk) disable iff (rst)
    (gclr_n && !clr_req && !pre_req && load) |=> (q == $past(d)));
  a_r11_comb_out: assert property (@(posedge clk) disable iff (rst)
    comb_sel |=> (cell_out == $past(sop)));
  a_r11_reg_out: assert property (@(posedge clk) disable iff (rst)
    !comb_sel |=> (cell_out == q));
endmodule

// File: rtl/pld_macrocell.sv
module pld_macrocell
  import mc_pkg::*;
#(
  parameter int N_IN  = 8,
  parameter int N_PT  = 5,
  parameter int N_EXP = 2,
  localparam int PTW  = (N_PT > 1) ? $clog2(N_PT) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N_IN-1:0]      in_vec,
  input  logic [N_EXP-1:0]     exp_in,
  input  logic                 gclk_a,
  input  logic                 gclk_b,
  input  logic                 clk_en,
  input  logic                 gclr_n,
  input  logic                 fast_in,
  input  logic [N_PT*N_IN-1:0] cfg_pt_use,
  input  logic [N_PT*N_IN-1:0] cfg_pt_inv,
  input  logic [N_PT-1:0]      cfg_pt_en,
  input  logic [N_EXP-1:0]     cfg_exp_en,
  input  logic [1:0]           cfg_clk_mode,
  input  logic                 cfg_gsel,
  input  logic                 cfg_ginv,
  input  logic [PTW-1:0]       cfg_arr_pt,
  input  logic                 cfg_pre_on,
  input  logic [PTW-1:0]       cfg_pre_pt,
  input  logic                 cfg_clr_on,
  input  logic [PTW-1:0]       cfg_clr_pt,
  input  logic                 cfg_fast,
  input  logic                 cfg_comb,
  output logic                 q_out,
  output logic                 cell_out
);
  localparam int SLOTS = 1 << PTW;

  logic [N_PT-1:0]  terms;
  logic [SLOTS-1:0] term_pad;
  logic             sop, load, d, pre_req, clr_req;

  mc_pterm_array #(.N_IN(N_IN), .N_PT(N_PT), .N_EXP(N_EXP)) u_terms (
    .in_vec  (in_vec),
    .use_mask(cfg_pt_use),
    .inv_mask(cfg_pt_inv),
    .pt_en   (cfg_pt_en),
    .exp_in  (exp_in),
    .exp_en  (cfg_exp_en),
    .terms   (terms),
    .sop     (sop)
  );

  mc_clk_select #(.N_PT(N_PT), .PTW(PTW)) u_clk (
    .clk    (clk),
    .rst    (rst),
    .gclk_a (gclk_a),
    .gclk_b (gclk_b),
    .gsel   (cfg_gsel),
    .ginv   (cfg_ginv),
    .mode   (ck_mode_e'(cfg_clk_mode)),
    .clk_en (clk_en),
    .terms  (terms),
    .arr_sel(cfg_arr_pt),
    .load   (load)
  );

  assign term_pad = SLOTS'(terms);
  assign pre_req  = cfg_pre_on & term_pad[cfg_pre_pt];
  assign clr_req  = cfg_clr_on & term_pad[cfg_clr_pt];
  assign d        = cfg_fast ? fast_in : sop;

  mc_reg_ctl u_reg (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .d       (d),
    .pre_req (pre_req),
    .clr_req (clr_req),
    .gclr_n  (gclr_n),
    .comb_sel(cfg_comb),
    .sop     (sop),
    .q       (q_out),
    .cell_out(cell_out)
  );
endmodule

// File: tb/tb_pld_macrocell.sv
module tb_pld_macrocell;
  localparam int NI = 8;
  localparam int NP = 5;
  localparam int NE = 2;
  localparam int PW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NI-1:0] in_v = '0;
  logic [NE-1:0] ex_v = '0;
  logic ga = 0, gb = 0, en = 0, gclr_n = 1, fin = 0;
  logic [NP*NI-1:0] use_v = '0, inv_v = '0;
  logic [NP-1:0] pten = '0;
  logic [NE-1:0] exen = '0;
  logic [1:0] mode = 2'd0;
  logic gsel = 0, ginv = 0, pre_on = 0, clr_on = 0, fast = 0, comb = 0;
  logic [PW-1:0] arr = '0, pre_pt = '0, clr_pt = '0;
  logic q_out, cell_out;

  int checks = 0, errors = 0;
  string tag = "R9";
  logic mq = 0, mout = 0, mprev = 1;

  always #5 clk = ~clk;

  pld_macrocell #(.N_IN(NI), .N_PT(NP), .N_EXP(NE)) dut (
    .clk(clk), .rst(rst), .in_vec(in_v), .exp_in(ex_v),
    .gclk_a(ga), .gclk_b(gb), .clk_en(en), .gclr_n(gclr_n), .fast_in(fin),
    .cfg_pt_use(use_v), .cfg_pt_inv(inv_v), .cfg_pt_en(pten),
    .cfg_exp_en(exen), .cfg_clk_mode(mode), .cfg_gsel(gsel),
    .cfg_ginv(ginv), .cfg_arr_pt(arr), .cfg_pre_on(pre_on),
    .cfg_pre_pt(pre_pt), .cfg_clr_on(clr_on), .cfg_clr_pt(clr_pt),
    .cfg_fast(fast), .cfg_comb(comb), .q_out(q_out), .cell_out(cell_out)
  );

  // reference model, written from the requirements
  function automatic logic m_term(int k);
    if (k >= NP) return 1'b0;
    for (int i = 0; i < NI; i++)
      if (use_v[k*NI+i] && ((in_v[i] ^ inv_v[k*NI+i]) == 1'b0)) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic m_sop();
    logic s = 1'b0;
    for (int k = 0; k < NP; k++) if (pten[k] && m_term(k)) s = 1'b1;
    for (int j = 0; j < NE; j++) if (exen[j] && ex_v[j]) s = 1'b1;
    return s;
  endfunction

  always @(posedge clk) begin
    logic g, fire, dv, sv;
    if (rst) begin
      mq = 0; mout = 0; mprev = 1;
    end else begin
      sv = m_sop();
      case (mode)
        2'd0, 2'd1: g = (gsel ? gb : ga) ^ ginv;
        2'd2:       g = m_term(int'(arr));
        default:    g = 1'b0;
      endcase
      fire  = g && !mprev && (mode != 2'd3) && (mode != 2'd1 || en);
      mprev = g;
      dv    = fast ? fin : sv;
      if (!gclr_n || (clr_on && m_term(int'(clr_pt)))) mq = 1'b0;
      else if (pre_on && m_term(int'(pre_pt)))          mq = 1'b1;
      else if (fire)                                    mq = dv;
      mout = comb ? sv : mq;
    end
  end

  task automatic compare();
    checks++;
    if (q_out !== mq) begin
      errors++;
      $display("FAIL %s q_out actual %b expected %b", tag, q_out, mq);
    end
    checks++;
    if (cell_out !== mout) begin
      errors++;
      $display("FAIL %s cell_out actual %b expected %b", tag, cell_out, mout);
    end
  endtask

  // flags: 1 in_vec, 2 expanders, 4 global clocks, 8 enable,
  //        16 global clear pulses, 32 fast pin
  task automatic run(string t, int n, int flags);
    tag = t;
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      compare();
      if (flags & 1)  in_v = NI'($urandom);
      if (flags & 2)  ex_v = NE'($urandom);
      if (flags & 4) begin ga = ga ^ $urandom_range(0, 1); gb = gb ^ $urandom_range(0, 1); end
      if (flags & 8)  en = $urandom_range(0, 1);
      if (flags & 16) gclr_n = ($urandom_range(0, 7) != 0);
      if (flags & 32) fin = $urandom_range(0, 1);
    end
  endtask

  task automatic sparse_terms();
    use_v = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
    inv_v = {$urandom, $urandom};
  endtask

  logic done = 0;

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    tag = "R9";
    compare();
    rst = 0;
    run("R9", 4, 0);
    // combinational path: R1 terms, R2 sum with expanders
    comb = 1;
    for (int r = 0; r < 6; r++) begin
      sparse_terms();
      pten = NP'($urandom);
      run("R1", 20, 1);
    end
    pten = '0; exen = '1;
    run("R2", 20, 3);
    pten = NP'($urandom); exen = 2'b01;
    run("R2", 30, 3);
    use_v = '0; pten = 5'b00001; exen = '0;
    run("R1", 5, 1);
    pten = '0;
    run("R2", 5, 1);
    // registered path
    comb = 0; sparse_terms(); pten = 5'b10110; exen = 2'b10;
    mode = 2'd0; gsel = 0; ginv = 0;
    run("R3", 200, 7);
    gsel = 1;
    run("R4", 150, 7);
    ginv = 1;
    run("R4", 150, 7);
    gsel = 0;
    run("R4", 100, 7);
    mode = 2'd1; ginv = 0;
    run("R5", 250, 15);
    // array clock on term 4, which uses only in_vec[0]
    mode = 2'd2; arr = 3'd4;
    use_v[4*NI +: NI] = 8'h01; inv_v[4*NI +: NI] = 8'h00;
    run("R6", 250, 3);
    arr = 3'd6;
    run("R6", 40, 7);
    mode = 2'd3;
    run("R6", 60, 7);
    // preset / clear terms while a global clock runs
    mode = 2'd0; sparse_terms();
    use_v[0 +: NI] = 8'h03; use_v[NI +: NI] = 8'h06;
    pre_on = 1; pre_pt = 3'd0; clr_on = 1; clr_pt = 3'd1;
    run("R7", 300, 7);
    in_v = 8'h07; inv_v[0 +: 2*NI] = '0;
    run("R7", 3, 4);
    clr_on = 0;
    run("R7", 3, 4);
    pre_on = 1; clr_on = 0;
    run("R8", 200, 23);
    pre_on = 0;
    fast = 1;
    run("R10", 250, 39);
    for (int r = 0; r < 8; r++) begin
      comb = $urandom_range(0, 1);
      run("R11", 40, 39);
    end
    fast = 0;
    rst = 1;
    run("R9", 3, 7);
    rst = 0;
    run("R9", 20, 7);
    done = 1;
  end

  initial begin
    for (int w = 0; w < 100000 && !done; w++) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired in %s", tag);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule